// File: doc/BRIEF.md
# Subset-Gated Low-Power Scan Controller

This block drives the scan clocks of one core under test so that only a single subset of its scan chains toggles at any time. It keeps a one-hot subset enable register. Every bit of that register passes through a hold stage, and the hold stage stays frozen while a shift pass runs. For each test vector the block walks through all subsets, one shift pass per subset. It then issues a single capture cycle on every chain together, followed by a completion pulse.

Clock gating is expressed as synchronous per-subset clock-enable outputs (`chain_ce`), so downstream clock cells stay outside this block. When test mode is off, every chain receives its functional clock without gating. A core-enable bit can silence all chains while the sequence still runs. The AND of core-enable and the class-select bit steers the select of the consumption-channel demultiplexer toward the scan inputs. The scan chains and the stimulus decompressor lie outside the block.

Top module: `lps_scan_ctrl`

## Requirements
- R1: After reset, with test mode on, `chain_ce` is all zeros and `capture`, `done` and `busy` are 0.
- R2: While `test_mode` is 0, every bit of `chain_ce` is 1.
- R3: A `start` sampled high while idle with `test_mode`=1 begins a vector. Counting the cycle after that edge as cycle 0, each pass p (p = 0 to NUM_SUBSETS-1, bit p of `chain_ce`) takes SHIFT_LEN+1 cycles. In the first cycle of a pass, `chain_ce` is all zeros. In the remaining SHIFT_LEN cycles, `chain_ce` is one-hot with only bit p set (when `core_en`=1).
- R4: The subset hold stage does not change during a shift pass, so `chain_ce` keeps one constant value through all SHIFT_LEN shift cycles of a pass.
- R5: In cycle NUM_SUBSETS*(SHIFT_LEN+1), `capture` is 1 for one cycle and every bit of `chain_ce` is 1 (when `core_en`=1).
- R6: `done` is 1 for exactly the one cycle after the capture cycle, and in the cycle after that the block is idle (`busy`=0, `chain_ce` all zeros).
- R7: With `test_mode`=1 and `core_en`=0, `chain_ce` stays all zeros throughout a vector, while `capture`, `done` and `busy` keep the timing of R3, R5 and R6.
- R8: `demux_sel` equals `core_en` AND `class_sel` (1 routes consumption-channel data to the scan inputs).
- R9: `start` is ignored while `busy` is 1, including during the done cycle. A `start` held high therefore begins the next vector only after one idle cycle.
- R10: `start` is ignored while `test_mode` is 0: `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test/functional clock reference |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 selects gated test clocking, 0 functional clocking |
| class_sel | input | 1 | Class-select bit for this core |
| core_en | input | 1 | Core-under-test enable bit |
| start | input | 1 | Begin one vector |
| chain_ce | output | NUM_SUBSETS | Per-subset scan clock enables |
| capture | output | 1 | Capture cycle marker |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Vector in progress |
| demux_sel | output | 1 | Consumption-channel demultiplexer select |

## Verification
Two things can fall in the same cycle: a fresh `start` request and the final cycles of a vector (done, or a shift pass in progress). The bench provokes this by holding `start` high across an entire vector and also by pulsing it in the middle of a pass. The scoreboard expects no disturbance to the pass timing and expects the second vector to begin exactly one idle cycle after `done`. A second overlap exists between the gating of `core_en` and capture: with `core_en` low, the capture and done pulses must still land in their cycles while every enable stays low.

// File: rtl/lps_pkg.sv
// Shared types for the subset-gated scan controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_CAPT,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/lps_enable_hold.sv
// One-hot subset enable register with a hold stage on every bit.
// Assumes: load_stb and hold_open never coincide; clear wins over both.
module lps_enable_hold #(
    parameter int NUM_SUBSETS = 10,
    parameter int IDX_W       = $clog2(NUM_SUBSETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_stb,
    input  logic [IDX_W-1:0]       load_idx,
    input  logic                   hold_open,
    input  logic                   clear,
    output logic [NUM_SUBSETS-1:0] hold_q
);
    logic [NUM_SUBSETS-1:0] en_reg;

    // Enable register: written one-hot with the next subset index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            en_reg <= '0;
        end else if (load_stb) begin
            for (int i = 0; i < NUM_SUBSETS; i++) begin
                en_reg[i] <= (IDX_W'(i) == load_idx);
            end
        end
    end

    // Per-bit hold stage: follows the register only while open.
    for (genvar b = 0; b < NUM_SUBSETS; b++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                hold_q[b] <= 1'b0;
            end else if (hold_open) begin
                hold_q[b] <= en_reg[b];
            end
        end
    end

    // R4: the held enables cannot move outside the load window
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_open && !clear) |=> $stable(hold_q));
endmodule

// File: rtl/lps_seq.sv
// Vector sequencer: load, shift each subset in turn, capture, done.
// Assumes: NUM_SUBSETS >= 2 and SHIFT_LEN >= 1.
module lps_seq
    import lps_pkg::*;
#(
    parameter int NUM_SUBSETS = 10,
    parameter int SHIFT_LEN   = 16,
    parameter int IDX_W       = $clog2(NUM_SUBSETS),
    parameter int CNT_W       = $clog2(SHIFT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             test_mode,
    output seq_state_t       state,
    output logic             load_stb,
    output logic [IDX_W-1:0] load_idx,
    output logic             hold_open,
    output logic             clear
);
    localparam logic [IDX_W-1:0] LAST_SUB = IDX_W'(NUM_SUBSETS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SHIFT_LEN - 1);

    logic [IDX_W-1:0] sub_idx;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             pass_end;

    // Decode start acceptance and end of a shift pass.
    always_comb begin
        accept   = (state == ST_IDLE) && start && test_mode;
        pass_end = (state == ST_SHIFT) && (cnt == LAST_CNT);
    end

    // Strobes toward the enable register and its hold stage.
    always_comb begin
        load_stb  = accept || (pass_end && (sub_idx != LAST_SUB));
        load_idx  = accept ? '0 : sub_idx + IDX_W'(1);
        hold_open = (state == ST_LOAD);
        clear     = (state == ST_DONE);
    end

    // State, subset index and shift counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sub_idx <= '0;
            cnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state   <= ST_LOAD;
                    sub_idx <= '0;
                end
                ST_LOAD: begin
                    cnt   <= '0;
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    cnt <= cnt + CNT_W'(1);
                    if (pass_end) begin
                        if (sub_idx == LAST_SUB) begin
                            state <= ST_CAPT;
                        end else begin
                            sub_idx <= sub_idx + IDX_W'(1);
                            state   <= ST_LOAD;
                        end
                    end
                end
                ST_CAPT: state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5/R6: capture is always followed by the done cycle
    p_capt_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPT) |=> (state == ST_DONE));
    // R6: done returns to idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
    // R9: a busy sequencer never re-enters its first pass on start
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_SHIFT) |=> (state != ST_LOAD || $past(state) == ST_IDLE));
endmodule

// File: rtl/lps_gate.sv
// Clock-enable generation per subset plus demultiplexer select.
// Assumes: hold_q is one-hot or zero.
module lps_gate #(
    parameter int NUM_SUBSETS = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   test_mode,
    input  logic                   core_en,
    input  logic                   class_sel,
    input  logic                   shifting,
    input  logic                   capturing,
    input  logic [NUM_SUBSETS-1:0] hold_q,
    output logic [NUM_SUBSETS-1:0] chain_ce,
    output logic                   demux_sel
);
    // Per-subset enable: test mux, core gate, subset or capture.
    for (genvar b = 0; b < NUM_SUBSETS; b++) begin : g_ce
        always_comb begin
            chain_ce[b] = test_mode ?
                (core_en && ((shifting && hold_q[b]) || capturing)) : 1'b1;
        end
    end

    // Demultiplexer select from the two global control bits.
    always_comb demux_sel = core_en && class_sel;

    // R3: at most one subset shifts at a time
    p_single_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && shifting) |-> $onehot0(chain_ce));
    // R7: a disabled core gets no scan clock
    p_core_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !core_en) |-> (chain_ce == '0));
    // R8: select never routes to scan without both bits
    p_demux_r8: assert property (@(posedge clk) disable iff (!rst_n)
        demux_sel |-> (core_en && class_sel));
endmodule

// File: rtl/lps_scan_ctrl.sv
// Top: subset-gated low-power scan controller for one core.
// Assumes: clock gating cells downstream consume chain_ce synchronously.
module lps_scan_ctrl
    import lps_pkg::*;
#(
    parameter int NUM_SUBSETS = 10,
    parameter int SHIFT_LEN   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   test_mode,
    input  logic                   class_sel,
    input  logic                   core_en,
    input  logic                   start,
    output logic [NUM_SUBSETS-1:0] chain_ce,
    output logic                   capture,
    output logic                   done,
    output logic                   busy,
    output logic                   demux_sel
);
    localparam int IDX_W = $clog2(NUM_SUBSETS);

    seq_state_t                state;
    logic                      load_stb;
    logic [IDX_W-1:0]          load_idx;
    logic                      hold_open;
    logic                      clear;
    logic [NUM_SUBSETS-1:0]    hold_q;

    lps_seq #(.NUM_SUBSETS(NUM_SUBSETS), .SHIFT_LEN(SHIFT_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .test_mode(test_mode),
        .state(state), .load_stb(load_stb), .load_idx(load_idx),
        .hold_open(hold_open), .clear(clear)
    );

    lps_enable_hold #(.NUM_SUBSETS(NUM_SUBSETS)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_idx(load_idx),
        .hold_open(hold_open), .clear(clear), .hold_q(hold_q)
    );

    lps_gate #(.NUM_SUBSETS(NUM_SUBSETS)) u_gate (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .core_en(core_en),
        .class_sel(class_sel), .shifting(state == ST_SHIFT),
        .capturing(state == ST_CAPT), .hold_q(hold_q),
        .chain_ce(chain_ce), .demux_sel(demux_sel)
    );

    // Status outputs decoded from the sequencer state.
    always_comb begin
        capture = (state == ST_CAPT);
        done    = (state == ST_DONE);
        busy    = (state != ST_IDLE);
    end

    // R10: functional mode never launches a vector
    p_no_start_func_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !test_mode) |=> !busy);
endmodule

// File: tb/test_lps_scan_ctrl.sv
module test_lps_scan_ctrl;
    localparam int K    = 10;
    localparam int L    = 16;
    localparam int VLEN = K * (L + 1);

    logic         clk = 1'b0;
    logic         rst_n, test_mode, class_sel, core_en, start;
    logic [K-1:0] chain_ce;
    logic         capture, done, busy, demux_sel;

    always #2 clk = ~clk;

    lps_scan_ctrl #(.NUM_SUBSETS(K), .SHIFT_LEN(L)) i_lps_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .class_sel(class_sel),
        .core_en(core_en), .start(start), .chain_ce(chain_ce),
        .capture(capture), .done(done), .busy(busy), .demux_sel(demux_sel)
    );

    typedef struct {
        logic [K-1:0] ce;
        logic         cap;
        logic         dn;
        logic         bsy;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic exp_t mk(logic [K-1:0] ce, logic cap, logic dn, logic bsy, string tag);
        exp_t e;
        e.ce = ce; e.cap = cap; e.dn = dn; e.bsy = bsy; e.tag = tag;
        return e;
    endfunction

    // Driver: expected items for one vector, one per cycle after the start edge.
    task automatic push_vector(input bit en);
        for (int n = 0; n < VLEN; n++) begin
            int s = n / (L + 1);
            int r = n % (L + 1);
            logic [K-1:0] oh = '0;
            if (r != 0 && en) oh[s] = 1'b1;
            q.push_back(mk(oh, 1'b0, 1'b0, 1'b1, en ? "R3 R4" : "R7"));
        end
        q.push_back(mk(en ? '1 : '0, 1'b1, 1'b0, 1'b1, en ? "R5" : "R7"));
        q.push_back(mk('0, 1'b0, 1'b1, 1'b1, "R6"));
        q.push_back(mk('0, 1'b0, 1'b0, 1'b0, "R6"));
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    // Monitor: pop and compare one expected item per cycle.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(chain_ce == e.ce && capture == e.cap && done == e.dn && busy == e.bsy,
                  e.tag, "ce/cap/done/busy",
                  {51'd0, chain_ce, capture, done, busy},
                  {51'd0, e.ce, e.cap, e.dn, e.bsy});
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; test_mode = 1; class_sel = 0; core_en = 1; start = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(chain_ce == '0, "R1", "chain_ce", chain_ce, 0);
        check(!capture && !done && !busy, "R1", "cap/done/busy",
              {capture, done, busy}, 0);

        // R3 R4 R5 R6: full vector with core enabled
        push_vector(1);
        start = 1;
        @(negedge clk);
        start = 0;
        drain();

        // R7: core disabled, timing unchanged, no enables
        core_en = 0;
        push_vector(0);
        start = 1;
        @(negedge clk);
        start = 0;
        drain();
        core_en = 1;

        // R9: start pulsed mid-pass is ignored
        push_vector(1);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (L + 5) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        drain();

        // R9: start held high over the done cycle; next vector after one idle cycle
        push_vector(1);
        push_vector(1);
        start = 1;
        repeat (VLEN + 4) @(negedge clk);
        start = 0;
        drain();

        // R2 R10: functional mode, all enables on, start ignored
        test_mode = 0;
        for (int i = 0; i < 5; i++) q.push_back(mk('1, 1'b0, 1'b0, 1'b0, "R2 R10"));
        start = 1;
        drain();
        start = 0;
        test_mode = 1;
        @(negedge clk);
        check(!busy && chain_ce == '0, "R10", "busy/ce after functional start",
              {busy, chain_ce}, 0);

        // R8: demux select truth table
        for (int v = 0; v < 4; v++) begin
            core_en   = v[0];
            class_sel = v[1];
            #1;
            check(demux_sel == (v[0] & v[1]), "R8", "demux_sel", demux_sel, v[0] & v[1]);
            @(negedge clk);
        end
        core_en = 1;
        class_sel = 0;

        finish_run();
    end
endmodule